// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Encoded External Level

This block collects interrupt requests from a fixed set of on-chip sources (timers, a real-time clock, a serial port, a watchdog and a DMA engine) plus one 4-bit encoded level from outside the chip. From all of these it selects a single winner and presents one registered request to the processor, together with the winner's 4-bit priority level and its 11-bit event code.

Software sets priorities through 16-bit priority registers. Each register holds four 4-bit fields. Sources of one peripheral group share a field, so a single write retunes the whole group. Individual sources are silenced through a mask that has two write addresses: one only sets mask bits and the other only clears them. Software can also read back the current event code on the same bus.

Top module: `prio_intc`

## Requirements
- R1: After reset, irq_req, irq_lvl and irq_code are 0, and every priority register and every mask bit reads as 0.
- R2: Priority field k lives in register k/4 (bus address k/4), bits [4*(k%4)+3 : 4*(k%4)]. A field value of 0 stops its sources from ever winning, even when they are pending.
- R3: Sources in a group share one field: field 2 serves sources 2–3 (timer 2), field 3 serves sources 4–6 (clock), field 5 serves sources 7–10 (serial) and field 6 serves sources 12–16 (DMA). Field 0 serves source 0, field 1 serves source 1 and field 4 serves source 11 (watchdog).
- R4: Internal source i has event code 0x400 + 0x20*i for i = 0..11. Sources 12..15 (DMA transfer end, channels 0..3) have codes 0x640, 0x660, 0x680 and 0x6A0, and source 16 (DMA address error) has code 0x6C0.
- R5: An external level value n from 0 to 14 requests event code 0x200 + 0x20*n at priority 15 − n. The value 15 requests nothing. The external input is not affected by the mask.
- R6: A write to the mask-set address (2) sets each mask bit whose write-data bit is 1 and leaves the bits written as 0 unchanged. Mask bit i silences source i.
- R7: A write to the mask-clear address (3) clears each mask bit whose write-data bit is 1 and leaves the bits written as 0 unchanged. Both addresses read back the mask.
- R8: The winner is the unmasked pending candidate with the highest nonzero priority. irq_req is high exactly when a winner exists.
- R9: When priorities are equal, the candidate with the lower event code wins. This includes an external request against an internal one.
- R10: irq_req, irq_lvl and irq_code are registered. They reflect the inputs and register contents of the previous clock edge, and they are 0 when there is no winner.
- R11: Reading address 4 returns irq_code in bits [10:0] with zeros above. All bus read data is registered, one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pend | input | 17 | Pending flags of the internal sources, bit i = source i |
| ext_lvl | input | 4 | Encoded external level, 15 = idle |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| irq_req | output | 1 | Request to the processor |
| irq_lvl | output | 4 | Priority of the winner |
| irq_code | output | 11 | Event code of the winner |

## Verification
The assertions assume that source pending flags and the external level are sampled synchronously to clk and that a bus write targets only one address per cycle. Because of that, the set and clear paths never compete in the same cycle. They also assume that every write to the mask addresses carries the full mask image in its low bits. The directed stimulus changes inputs only on the falling edge and issues one write per cycle, which keeps it within these assumptions. It also returns the external level to the idle value 15 between scenarios, so each check sees only the candidates it sets up.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
   localparam int NUM_SRC = 17;
   localparam int LVL_W   = 4;
   localparam int CODE_W  = 11;
   localparam int NUM_CAND = NUM_SRC + 1;
   localparam logic [LVL_W-1:0] EXT_IDLE = 4'hF;

   typedef struct packed {
      logic              req;
      logic [LVL_W-1:0]  lvl;
      logic [CODE_W-1:0] code;
   } win_t;

   // Event code of internal source i.
   function automatic logic [CODE_W-1:0] src_code(input int i);
      if (i < 12) return CODE_W'(11'h400 + 11'(i) * 11'h20);
      else        return CODE_W'(11'h640 + 11'(i - 12) * 11'h20);
   endfunction

   // Priority field that serves internal source i.
   function automatic int src_field(input int i);
      case (i)
         0:               return 0;
         1:               return 1;
         2, 3:            return 2;
         4, 5, 6:         return 3;
         7, 8, 9, 10:     return 5;
         11:              return 4;
         default:         return 6;
      endcase
   endfunction
endpackage

// File: rtl/prio_intc_cfg.sv
module prio_intc_cfg
   import prio_intc_pkg::*;
#(
   parameter int PRIO_REGS = 2,
   parameter int PRIO_W    = 16,
   parameter int MASK_W    = 32,
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [DATA_W-1:0]               wdata,
   output logic [PRIO_REGS*PRIO_W-1:0]     prio_flat,
   output logic [MASK_W-1:0]               mask,
   output logic [DATA_W-1:0]               rdata
);
   localparam int SET_A = PRIO_REGS;
   localparam int CLR_A = PRIO_REGS + 1;

   logic [PRIO_W-1:0] prio_q [PRIO_REGS];
   logic [MASK_W-1:0] mask_q;

   genvar g;
   generate
      for (g = 0; g < PRIO_REGS; g++) begin : g_prio
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               prio_q[g] <= '0;
            else if (we && addr == ADDR_W'(g))
               prio_q[g] <= wdata[PRIO_W-1:0];
         end
         assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (we && addr == ADDR_W'(SET_A))
         mask_q <= mask_q | wdata[MASK_W-1:0];
      else if (we && addr == ADDR_W'(CLR_A))
         mask_q <= mask_q & ~wdata[MASK_W-1:0];
   end

   assign mask = mask_q;

   always_comb begin
      rdata = '0;
      for (int r = 0; r < PRIO_REGS; r++)
         if (addr == ADDR_W'(r)) rdata[PRIO_W-1:0] = prio_q[r];
      if (addr == ADDR_W'(SET_A) || addr == ADDR_W'(CLR_A))
         rdata[MASK_W-1:0] = mask_q;
   end
endmodule

// File: rtl/prio_intc_ext.sv
module prio_intc_ext
   import prio_intc_pkg::*;
(
   input  logic [LVL_W-1:0]  ext_lvl,
   output logic [LVL_W-1:0]  lvl,
   output logic [CODE_W-1:0] code
);
   always_comb begin
      if (ext_lvl == EXT_IDLE) begin
         lvl  = '0;
         code = '0;
      end else begin
         lvl  = EXT_IDLE - ext_lvl;
         code = CODE_W'(11'h200 + {2'b0, ext_lvl, 5'b0});
      end
   end
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
   import prio_intc_pkg::*;
#(
   parameter int NC = NUM_CAND
) (
   input  logic [NC-1:0][LVL_W-1:0]  cand_lvl,
   input  logic [NC-1:0][CODE_W-1:0] cand_code,
   output win_t                      win
);
   // Candidates arrive in ascending event-code order; a strict compare
   // keeps the earlier (lower code) one on equal priority.
   always_comb begin
      win = '0;
      for (int c = 0; c < NC; c++) begin
         if (cand_lvl[c] > win.lvl) begin
            win.req  = 1'b1;
            win.lvl  = cand_lvl[c];
            win.code = cand_code[c];
         end
      end
   end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import prio_intc_pkg::*;
#(
   parameter int PRIO_REGS = 2,
   parameter int PRIO_W    = 16,
   parameter int MASK_W    = 32,
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   src_pend,
   input  logic [LVL_W-1:0]     ext_lvl,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 irq_req,
   output logic [LVL_W-1:0]     irq_lvl,
   output logic [CODE_W-1:0]    irq_code
);
   localparam int FIELDS   = PRIO_REGS * (PRIO_W / LVL_W);
   localparam int CODE_A   = PRIO_REGS + 2;

   generate
      if (PRIO_W % LVL_W != 0) begin : g_bad_w
         $error("priority register width must hold whole fields");
      end
      if (NUM_SRC > MASK_W || MASK_W > DATA_W) begin : g_bad_mask
         $error("mask too narrow for sources or too wide for bus");
      end
      if (PRIO_REGS + 3 > (1 << ADDR_W)) begin : g_bad_addr
         $error("address space too small for register set");
      end
      if (FIELDS < 7) begin : g_bad_fields
         $error("source map needs at least seven priority fields");
      end
   endgenerate

   logic [PRIO_REGS*PRIO_W-1:0] prio_flat;
   logic [MASK_W-1:0]           mask_all;
   logic [NUM_SRC-1:0]          mask_vec;
   logic [DATA_W-1:0]           cfg_rdata;

   prio_intc_cfg #(
      .PRIO_REGS(PRIO_REGS), .PRIO_W(PRIO_W), .MASK_W(MASK_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .prio_flat(prio_flat), .mask(mask_all),
      .rdata(cfg_rdata)
   );

   assign mask_vec = mask_all[NUM_SRC-1:0];

   logic [NUM_CAND-1:0][LVL_W-1:0]  cand_lvl;
   logic [NUM_CAND-1:0][CODE_W-1:0] cand_code;

   prio_intc_ext u_ext (
      .ext_lvl(ext_lvl), .lvl(cand_lvl[0]), .code(cand_code[0])
   );

   genvar s;
   generate
      for (s = 0; s < NUM_SRC; s++) begin : g_src
         localparam int FLD = src_field(s);
         logic [LVL_W-1:0] fld_val;
         assign fld_val = prio_flat[FLD*LVL_W +: LVL_W];
         assign cand_lvl[s+1]  = (src_pend[s] && !mask_vec[s]) ? fld_val : '0;
         assign cand_code[s+1] = src_code(s);
      end
   endgenerate

   win_t win, win_q;

   prio_intc_arb #(.NC(NUM_CAND)) u_arb (
      .cand_lvl(cand_lvl), .cand_code(cand_code), .win(win)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q     <= '0;
         bus_rdata <= '0;
      end else begin
         win_q     <= win;
         bus_rdata <= (bus_addr == ADDR_W'(CODE_A))
                      ? DATA_W'(win_q.code) : cfg_rdata;
      end
   end

   assign irq_req  = win_q.req;
   assign irq_lvl  = win_q.lvl;
   assign irq_code = win_q.code;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
   import prio_intc_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int SET_A  = 2,
   parameter int CLR_A  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_pend,
   input logic [LVL_W-1:0]   ext_lvl,
   input logic [NUM_SRC-1:0] mask_vec,
   input logic               bus_we,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [NUM_SRC-1:0] wdata_lo,
   input logic               irq_req,
   input logic [LVL_W-1:0]   irq_lvl,
   input logic [CODE_W-1:0]  irq_code
);
   p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(SET_A)) |=>
         ((mask_vec & $past(wdata_lo)) == $past(wdata_lo)));

   p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(CLR_A)) |=>
         ((mask_vec & $past(wdata_lo)) == '0));

   p_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_lvl != EXT_IDLE) |=>
         (irq_req && irq_lvl >= (EXT_IDLE - $past(ext_lvl))));

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_lvl == EXT_IDLE && (src_pend & ~mask_vec) == '0) |=> !irq_req);

   p_lvl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_lvl != '0);

   p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (irq_lvl == '0 && irq_code == '0));
endmodule

bind prio_intc prio_intc_chk #(
   .ADDR_W(ADDR_W), .SET_A(PRIO_REGS), .CLR_A(PRIO_REGS + 1)
) u_chk (
   .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .ext_lvl(ext_lvl),
   .mask_vec(mask_vec), .bus_we(bus_we), .bus_addr(bus_addr),
   .wdata_lo(bus_wdata[prio_intc_pkg::NUM_SRC-1:0]),
   .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_code(irq_code)
);

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 17;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [NS-1:0] src_pend = '0;
   logic [3:0]    ext_lvl = 4'hF;
   logic          bus_we = 0;
   logic [2:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_req;
   logic [3:0]    irq_lvl;
   logic [10:0]   irq_code;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_intc u_dut (
      .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .ext_lvl(ext_lvl),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_lvl(irq_lvl),
      .irq_code(irq_code)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_out(input string req, input logic r, input logic [3:0] l, input logic [10:0] c);
      chk({req, " req"}, 32'(irq_req), 32'(r));
      chk({req, " lvl"}, 32'(irq_lvl), 32'(l));
      chk({req, " code"}, 32'(irq_code), 32'(c));
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 0; bus_wdata = '0;
      @(negedge clk);
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic drive(input logic [NS-1:0] p, input logic [3:0] e);
      @(negedge clk);
      src_pend = p; ext_lvl = e;
      @(negedge clk);
   endtask

   task automatic clean();
      drive('0, 4'hF);
      wr(3'd0, 0); wr(3'd1, 0); wr(3'd3, 32'hFFFF_FFFF);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk_out("R1", 0, 0, 0);
      rd(3'd0, d); chk("R1 prio0", d, 0);
      rd(3'd1, d); chk("R1 prio1", d, 0);
      rd(3'd2, d); chk("R1 mask", d, 0);
   endtask

   task automatic t_zero_field();
      clean();
      drive('1, 4'hF);
      chk_out("R2 zero field", 0, 0, 0);
      wr(3'd1, 32'h0000_0300);          // field 6 (dma) at reg1 bits 11:8
      drive(17'h01000, 4'hF);
      chk_out("R2 field6 placement", 1, 3, 11'h640);
   endtask

   task automatic t_single();
      clean();
      wr(3'd0, 32'h0005);
      @(negedge clk); src_pend = 17'h1;
      @(negedge clk);                   // exactly one rising edge later
      chk_out("R10 one-cycle R4 tmr0", 1, 5, 11'h400);
   endtask

   task automatic t_group();
      clean();
      wr(3'd0, 32'h7000);               // field 3: clock group
      drive(17'h00020, 4'hF); chk_out("R3 clock src5", 1, 7, 11'h4A0);
      drive(17'h00040, 4'hF); chk_out("R3 clock src6", 1, 7, 11'h4C0);
      wr(3'd1, 32'h0001);               // field 4: watchdog
      drive(17'h00800, 4'hF); chk_out("R3 wdt src11", 1, 1, 11'h560);
   endtask

   task automatic t_priority();
      clean();
      wr(3'd0, 32'h0092);               // tmr0=2 tmr1=9
      drive(17'h3, 4'hF); chk_out("R8 higher wins", 1, 9, 11'h420);
   endtask

   task automatic t_tie();
      clean();
      wr(3'd0, 32'h0044);
      drive(17'h3, 4'hF); chk_out("R9 tie timers", 1, 4, 11'h400);
      wr(3'd1, 32'h0060);               // field 5: serial
      drive(17'h00300, 4'hF); chk_out("R9 tie serial", 1, 6, 11'h500);
   endtask

   task automatic t_dma();
      clean();
      wr(3'd1, 32'h0A00);
      for (int j = 0; j < 5; j++) begin
         drive(17'(1) << (12 + j), 4'hF);
         chk_out("R4 dma code", 1, 4'hA, 11'(11'h640 + j * 11'h20));
      end
   endtask

   task automatic t_ext();
      clean();
      drive('0, 4'd0);  chk_out("R5 ext 0", 1, 15, 11'h200);
      drive('0, 4'd14); chk_out("R5 ext 14", 1, 1, 11'h3C0);
      drive('0, 4'd7);  chk_out("R5 ext 7", 1, 8, 11'h2E0);
      drive('0, 4'd15); chk_out("R5 ext idle", 0, 0, 0);
      wr(3'd0, 32'h0005);
      drive(17'h1, 4'd10); chk_out("R9 ext tie", 1, 5, 11'h340);
      drive(17'h1, 4'd11); chk_out("R8 int over ext", 1, 5, 11'h400);
      wr(3'd2, 32'h1);
      drive(17'h1, 4'd12); chk_out("R5 ext unmasked", 1, 3, 11'h380);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      clean();
      wr(3'd0, 32'h0005);
      drive(17'h1, 4'hF);
      wr(3'd2, 32'h1);  chk_out("R6 set masks", 0, 0, 0);
      wr(3'd2, 32'h0);  rd(3'd2, d); chk("R6 zero no effect", d, 1);
      chk_out("R6 still masked", 0, 0, 0);
      wr(3'd3, 32'h0);  rd(3'd3, d); chk("R7 zero no effect", d, 1);
      wr(3'd3, 32'h1);  chk_out("R7 clear unmasks", 1, 5, 11'h400);
      wr(3'd2, 32'h3);  wr(3'd3, 32'h2);
      rd(3'd2, d); chk("R7 partial clear", d, 1);
   endtask

   task automatic t_read();
      logic [31:0] d;
      clean();
      wr(3'd0, 32'h0050);
      drive(17'h2, 4'hF);
      rd(3'd4, d); chk("R11 code readback", d, 32'h420);
      rd(3'd0, d); chk("R11 prio readback", d, 32'h0050);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_zero_field();
      t_single();
      t_group();
      t_priority();
      t_tie();
      t_dma();
      t_ext();
      t_mask();
      t_read();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule